// File: doc/BRIEF.md
# Input Sample Rate Lock Detector

This block watches the frame clock of an incoming serial audio stream and decides which standard rate it carries. In PCM mode the observed clock is the word clock; in 1-bit DSD mode it is the bit clock. Every rising edge of that clock is brought into a fixed 24.576 MHz reference domain. The block then counts reference cycles across a fixed number of input periods and compares the count with a precomputed acceptance window for each standard rate.

A rate is accepted only within ±2% of its nominal value. The block declares lock only after two measurements in a row give the same standard rate. A single bad measurement drops lock at once.

The result is reported on three outputs: a 4-bit rate code, a locked flag and an active-low interrupt line. Downstream logic uses these to gate sample processing and to tell a host that the rate has moved. An external active-low data-valid input can hold the detector unlocked for as long as it stays high. Measurement lengths and the tolerance are parameters, and the acceptance windows are worked out from them when the block is elaborated.

Top module: `rate_lock_detect`

## Requirements
- R1: After reset, the rate code is 0, the locked flag is low and the interrupt line is high.
- R2: With the mode select low, an input word clock at 32, 44.1, 48, 88.2, 96, 176.4, 192, 352.8 or 384 kHz is reported as rate code 1, 2, 3, 4, 5, 6, 7, 8 or 9 respectively, with the locked flag high.
- R3: With the mode select high, an input bit clock at 2.8224, 3.072, 5.6448 or 6.144 MHz is reported as rate code 10, 11, 12 or 13 respectively, with the locked flag high.
- R4: An input within ±2% of a standard rate is accepted as that rate. An input 4% away from every standard rate is reported as unlocked with code 0.
- R5: A non-standard input rate (for example 64 kHz in PCM mode) leaves the block unlocked with code 0.
- R6: A measurement spans PCM_PERIODS input periods in PCM mode and DSD_PERIODS in DSD mode. Lock is declared only when two consecutive measurements match the same standard rate, so one window after the input starts, the block is still unlocked.
- R7: When a locked input changes to another standard rate, lock is dropped and the interrupt line goes low. The block then relocks with the new rate code and the interrupt line returns high.
- R8: While the data-valid input is high, the block is unlocked with code 0 within a few cycles and never locks. After the input returns low, lock is reacquired.
- R9: If the input clock stops, the block reports unlocked once the measurement window times out.
- R10: The interrupt line falls in the same cycle that lock is lost and rises in the same cycle that lock is gained. It is high whenever the block is locked.
- R11: The rate code is nonzero exactly when the locked flag is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | 24.576 MHz reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_clk_i | input | 1 | Input word clock (PCM) or bit clock (DSD), asynchronous |
| dsd_mode_i | input | 1 | 1 selects DSD bit-rate classification, 0 selects PCM |
| valid_n_i | input | 1 | Active-low data-valid; high holds the block unlocked |
| rate_code_o | output | 4 | Detected rate code, 0 when unlocked |
| locked_o | output | 1 | High while a standard rate is locked |
| irq_n_o | output | 1 | Active-low interrupt, low after lock loss until relock |

## Verification
The block is driven with exact nominal clocks at several PCM rates, from the slowest to the fastest, and at all four DSD bit rates. This shows that each window maps to its own code in each mode. Clocks 1.5% off nominal and 4% off nominal test the acceptance edge on both sides of 48 kHz, and 64 kHz tests a rate that sits between windows. A live switch from 48 to 96 kHz, a held data-valid input and a stopped clock test the three ways lock can be lost, each of which must pull the interrupt low. Sampling one window and then two windows after data-valid is released tests the two-measurement rule.

// File: rtl/rld_pkg.sv
package rld_pkg;

  localparam int RATE_CODE_W = 4;
  localparam int PCM_RATES   = 9;
  localparam int DSD_RATES   = 4;

  typedef logic [RATE_CODE_W-1:0] rate_code_t;
  typedef logic [63:0]            cnt64_t;

  localparam rate_code_t CODE_UNLOCKED  = 4'd0;
  localparam rate_code_t CODE_DSD_FIRST = 4'd10;

  // PCM frame rates in ascending order; index i maps to code i+1
  function automatic cnt64_t pcm_rate_hz(int idx);
    case (idx)
      0:       return 64'd32000;
      1:       return 64'd44100;
      2:       return 64'd48000;
      3:       return 64'd88200;
      4:       return 64'd96000;
      5:       return 64'd176400;
      6:       return 64'd192000;
      7:       return 64'd352800;
      default: return 64'd384000;
    endcase
  endfunction

  // DSD bit rates in ascending order; index j maps to code 10+j
  function automatic cnt64_t dsd_rate_hz(int idx);
    case (idx)
      0:       return 64'd2822400;
      1:       return 64'd3072000;
      2:       return 64'd5644800;
      default: return 64'd6144000;
    endcase
  endfunction

  function automatic cnt64_t nominal_count(cnt64_t ref_hz, cnt64_t periods, cnt64_t rate_hz);
    return (ref_hz * periods + rate_hz / 2) / rate_hz;
  endfunction

  function automatic cnt64_t low_bound(cnt64_t nom, cnt64_t tol_pct);
    return (nom * (64'd100 - tol_pct) + 64'd99) / 64'd100;
  endfunction

  function automatic cnt64_t high_bound(cnt64_t nom, cnt64_t tol_pct);
    return (nom * (64'd100 + tol_pct)) / 64'd100;
  endfunction

  // Longest accepted window plus one: a run reaching it can match nothing
  function automatic cnt64_t timeout_count(cnt64_t ref_hz, cnt64_t pcm_per,
                                           cnt64_t dsd_per, cnt64_t tol_pct);
    cnt64_t a;
    cnt64_t b;
    a = high_bound(nominal_count(ref_hz, pcm_per, pcm_rate_hz(0)), tol_pct);
    b = high_bound(nominal_count(ref_hz, dsd_per, dsd_rate_hz(0)), tol_pct);
    return ((a > b) ? a : b) + 64'd1;
  endfunction

endpackage

// File: rtl/rld_sync.sv
module rld_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/rld_edge_detect.sv
module rld_edge_detect #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  output logic rise_o
);

  logic level;
  logic prev_q;

  rld_sync #(.STAGES(STAGES), .RST_VAL(1'b0)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (sig_i),
    .q_o   (level)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level;
  end

  assign rise_o = level & ~prev_q;

endmodule

// File: rtl/rld_period_counter.sv
module rld_period_counter #(
  parameter int PCM_PERIODS = 16,
  parameter int DSD_PERIODS = 512,
  parameter int LIMIT       = 12534,
  parameter int CNT_W       = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise_i,
  input  logic             hold_i,
  input  logic             dsd_i,
  output logic             meas_valid_o,
  output logic             meas_timeout_o,
  output logic [CNT_W-1:0] meas_cnt_o
);

  localparam int MAX_PER = (PCM_PERIODS > DSD_PERIODS) ? PCM_PERIODS : DSD_PERIODS;
  localparam int EDG_W   = $clog2(MAX_PER + 1);
  localparam logic [CNT_W-1:0] LIMIT_C    = CNT_W'(LIMIT);
  localparam logic [EDG_W-1:0] LAST_PCM_C = EDG_W'(PCM_PERIODS - 1);
  localparam logic [EDG_W-1:0] LAST_DSD_C = EDG_W'(DSD_PERIODS - 1);

  logic             run_q,  run_d;
  logic             mode_q;
  logic [CNT_W-1:0] cyc_q,  cyc_d;
  logic [EDG_W-1:0] edg_q,  edg_d;
  logic [EDG_W-1:0] last_edg;
  logic             mode_chg;

  assign last_edg = dsd_i ? LAST_DSD_C : LAST_PCM_C;
  assign mode_chg = dsd_i ^ mode_q;

  always_comb begin
    run_d          = run_q;
    cyc_d          = cyc_q;
    edg_d          = edg_q;
    meas_valid_o   = 1'b0;
    meas_timeout_o = 1'b0;
    meas_cnt_o     = cyc_q + 1'b1;
    if (hold_i || mode_chg) begin
      run_d = 1'b0;
      cyc_d = '0;
      edg_d = '0;
    end else if (!run_q) begin
      if (rise_i) begin
        run_d = 1'b1;
        cyc_d = '0;
        edg_d = '0;
      end
    end else if (rise_i && (edg_q == last_edg)) begin
      meas_valid_o = 1'b1;
      cyc_d        = '0;
      edg_d        = '0;
    end else if (cyc_q == LIMIT_C) begin
      meas_valid_o   = 1'b1;
      meas_timeout_o = 1'b1;
      run_d          = 1'b0;
      cyc_d          = '0;
      edg_d          = '0;
    end else begin
      cyc_d = cyc_q + 1'b1;
      if (rise_i) edg_d = edg_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      mode_q <= 1'b0;
      cyc_q  <= '0;
      edg_q  <= '0;
    end else begin
      run_q  <= run_d;
      mode_q <= dsd_i;
      cyc_q  <= cyc_d;
      edg_q  <= edg_d;
    end
  end

  // R9: a timed-out window returns the counter to idle
  p_timeout_idles_r9: assert property (@(posedge clk) disable iff (!rst_n)
    meas_timeout_o |=> !run_q);
  // R9: the window counter never runs past its limit
  p_cycle_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cyc_q <= LIMIT_C));
  // R8: no measurement completes while held off
  p_hold_no_meas_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |-> !meas_valid_o);

endmodule

// File: rtl/rld_rate_classify.sv
module rld_rate_classify
  import rld_pkg::*;
#(
  parameter int REF_HZ      = 24576000,
  parameter int PCM_PERIODS = 16,
  parameter int DSD_PERIODS = 512,
  parameter int TOL_PCT     = 2,
  parameter int CNT_W       = 14
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             timeout_i,
  input  logic             dsd_i,
  output rate_code_t       code_o
);

  cnt64_t               cnt_wide;
  logic [PCM_RATES-1:0] pcm_hit;
  logic [DSD_RATES-1:0] dsd_hit;

  assign cnt_wide = cnt64_t'(cnt_i);

  for (genvar gi = 0; gi < PCM_RATES; gi++) begin : g_pcm
    localparam cnt64_t NOM = nominal_count(cnt64_t'(REF_HZ), cnt64_t'(PCM_PERIODS), pcm_rate_hz(gi));
    localparam cnt64_t LO  = low_bound(NOM, cnt64_t'(TOL_PCT));
    localparam cnt64_t HI  = high_bound(NOM, cnt64_t'(TOL_PCT));
    assign pcm_hit[gi] = (cnt_wide >= LO) && (cnt_wide <= HI);
  end

  for (genvar gj = 0; gj < DSD_RATES; gj++) begin : g_dsd
    localparam cnt64_t NOM = nominal_count(cnt64_t'(REF_HZ), cnt64_t'(DSD_PERIODS), dsd_rate_hz(gj));
    localparam cnt64_t LO  = low_bound(NOM, cnt64_t'(TOL_PCT));
    localparam cnt64_t HI  = high_bound(NOM, cnt64_t'(TOL_PCT));
    assign dsd_hit[gj] = (cnt_wide >= LO) && (cnt_wide <= HI);
  end

  always_comb begin
    code_o = CODE_UNLOCKED;
    if (!timeout_i) begin
      if (dsd_i) begin
        for (int j = 0; j < DSD_RATES; j++) begin
          if (dsd_hit[j]) code_o = CODE_DSD_FIRST + rate_code_t'(j);
        end
      end else begin
        for (int i = 0; i < PCM_RATES; i++) begin
          if (pcm_hit[i]) code_o = rate_code_t'(i + 1);
        end
      end
    end
  end

endmodule

// File: rtl/rld_lock_fsm.sv
module rld_lock_fsm
  import rld_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       meas_valid_i,
  input  rate_code_t code_i,
  input  logic       bad_i,
  output logic       lock_o,
  output rate_code_t code_o,
  output logic       irq_n_o
);

  logic       lock_q, lock_d;
  rate_code_t code_q, code_d;
  rate_code_t cand_q, cand_d;
  logic       irq_n_q, irq_n_d;

  always_comb begin
    lock_d  = lock_q;
    code_d  = code_q;
    cand_d  = cand_q;
    if (bad_i) begin
      lock_d = 1'b0;
      code_d = CODE_UNLOCKED;
      cand_d = CODE_UNLOCKED;
    end else if (meas_valid_i) begin
      if (code_i == CODE_UNLOCKED) begin
        lock_d = 1'b0;
        code_d = CODE_UNLOCKED;
        cand_d = CODE_UNLOCKED;
      end else if (lock_q && (code_i == code_q)) begin
        lock_d = 1'b1;
      end else if (code_i == cand_q) begin
        lock_d = 1'b1;
        code_d = code_i;
      end else begin
        lock_d = 1'b0;
        code_d = CODE_UNLOCKED;
        cand_d = code_i;
      end
    end
  end

  always_comb begin
    irq_n_d = irq_n_q;
    if (lock_d && !lock_q)      irq_n_d = 1'b1;
    else if (!lock_d && lock_q) irq_n_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q  <= 1'b0;
      code_q  <= CODE_UNLOCKED;
      cand_q  <= CODE_UNLOCKED;
      irq_n_q <= 1'b1;
    end else begin
      lock_q  <= lock_d;
      code_q  <= code_d;
      cand_q  <= cand_d;
      irq_n_q <= irq_n_d;
    end
  end

  assign lock_o  = lock_q;
  assign code_o  = code_q;
  assign irq_n_o = irq_n_q;

  p_code_vs_lock_r11: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q == (code_q != CODE_UNLOCKED));
  p_irq_high_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |-> irq_n_q);
  p_irq_on_loss_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_q) |-> !irq_n_q);
  p_holdoff_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bad_i |=> !lock_q);
  p_reject_unlocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_valid_i && (code_i == CODE_UNLOCKED)) |=> !lock_q);
  p_lock_from_meas_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_q) |-> $past(meas_valid_i));

endmodule

// File: rtl/rate_lock_detect.sv
module rate_lock_detect
  import rld_pkg::*;
#(
  parameter int REF_HZ      = 24576000,
  parameter int PCM_PERIODS = 16,
  parameter int DSD_PERIODS = 512,
  parameter int TOL_PCT     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_ref,
  input  logic       rst_n,
  input  logic       rate_clk_i,
  input  logic       dsd_mode_i,
  input  logic       valid_n_i,
  output logic [3:0] rate_code_o,
  output logic       locked_o,
  output logic       irq_n_o
);

  localparam int LIMIT = int'(timeout_count(cnt64_t'(REF_HZ), cnt64_t'(PCM_PERIODS),
                                            cnt64_t'(DSD_PERIODS), cnt64_t'(TOL_PCT)));
  localparam int CNT_W = $clog2(LIMIT + 2);

  logic             rise;
  logic             bad;
  logic             meas_valid;
  logic             meas_timeout;
  logic [CNT_W-1:0] meas_cnt;
  rate_code_t       meas_code;
  rate_code_t       lock_code;

  rld_edge_detect #(.STAGES(SYNC_STAGES)) u_edge (
    .clk    (clk_ref),
    .rst_n  (rst_n),
    .sig_i  (rate_clk_i),
    .rise_o (rise)
  );

  rld_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_valid_sync (
    .clk   (clk_ref),
    .rst_n (rst_n),
    .d_i   (valid_n_i),
    .q_o   (bad)
  );

  rld_period_counter #(
    .PCM_PERIODS (PCM_PERIODS),
    .DSD_PERIODS (DSD_PERIODS),
    .LIMIT       (LIMIT),
    .CNT_W       (CNT_W)
  ) u_counter (
    .clk            (clk_ref),
    .rst_n          (rst_n),
    .rise_i         (rise),
    .hold_i         (bad),
    .dsd_i          (dsd_mode_i),
    .meas_valid_o   (meas_valid),
    .meas_timeout_o (meas_timeout),
    .meas_cnt_o     (meas_cnt)
  );

  rld_rate_classify #(
    .REF_HZ      (REF_HZ),
    .PCM_PERIODS (PCM_PERIODS),
    .DSD_PERIODS (DSD_PERIODS),
    .TOL_PCT     (TOL_PCT),
    .CNT_W       (CNT_W)
  ) u_classify (
    .cnt_i     (meas_cnt),
    .timeout_i (meas_timeout),
    .dsd_i     (dsd_mode_i),
    .code_o    (meas_code)
  );

  rld_lock_fsm u_lock (
    .clk          (clk_ref),
    .rst_n        (rst_n),
    .meas_valid_i (meas_valid),
    .code_i       (meas_code),
    .bad_i        (bad),
    .lock_o       (locked_o),
    .code_o       (lock_code),
    .irq_n_o      (irq_n_o)
  );

  assign rate_code_o = lock_code;

endmodule

// File: tb/rate_lock_detect_tb_top.sv
module rate_lock_detect_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  localparam real CLK_PERIOD_NS = 40.690;
  localparam real REF_HZ_R      = 24576000.0;
  localparam int  PCM_PER       = 4;
  localparam int  DSD_PER       = 128;
  localparam int  WATCHDOG      = 190000;

  logic       clk_ref    = 1'b0;
  logic       rst_n      = 1'b0;
  logic       rate_clk_i = 1'b0;
  logic       dsd_mode_i = 1'b0;
  logic       valid_n_i  = 1'b1;
  logic [3:0] rate_code_o;
  logic       locked_o;
  logic       irq_n_o;

  int  checks   = 0;
  int  failures = 0;
  int  prev_win = 0;
  real half_ns  = 1000.0;
  bit  gen_on   = 1'b0;
  bit  irq_low_seen = 1'b0;
  bit  done     = 1'b0;

  rate_lock_detect #(.PCM_PERIODS(PCM_PER), .DSD_PERIODS(DSD_PER)) dut_i (
    .clk_ref     (clk_ref),
    .rst_n       (rst_n),
    .rate_clk_i  (rate_clk_i),
    .dsd_mode_i  (dsd_mode_i),
    .valid_n_i   (valid_n_i),
    .rate_code_o (rate_code_o),
    .locked_o    (locked_o),
    .irq_n_o     (irq_n_o)
  );

  always #(CLK_PERIOD_NS / 2.0) clk_ref = ~clk_ref;

  always begin
    if (gen_on) begin
      #(half_ns);
      rate_clk_i = ~rate_clk_i;
    end else begin
      #(CLK_PERIOD_NS);
    end
  end

  always @(negedge clk_ref) begin
    if (rst_n && !irq_n_o) irq_low_seen = 1'b1;
  end

  task automatic check(string tag, int act, int expv);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(posedge clk_ref);
    @(negedge clk_ref);
  endtask

  function automatic int win_cycles(real hz, bit dsd);
    return int'((dsd ? DSD_PER : PCM_PER) * REF_HZ_R / hz);
  endfunction

  task automatic settle(real hz, bit dsd);
    int w;
    dsd_mode_i = dsd;
    half_ns    = 1.0e9 / (2.0 * hz);
    gen_on     = 1'b1;
    w = win_cycles(hz, dsd);
    wait_clk(4 * w + prev_win + 128);
    prev_win = w;
  endtask

  task automatic expect_lock(string tag, int code);
    check({tag, " locked"}, int'(locked_o), 1);
    check({tag, " code"}, int'(rate_code_o), code);
    check({tag, " R10 irq_n high while locked"}, int'(irq_n_o), 1);
    check({tag, " R11 code nonzero iff locked"}, int'((rate_code_o != 0) == locked_o), 1);
  endtask

  task automatic expect_unlock(string tag);
    check({tag, " locked"}, int'(locked_o), 0);
    check({tag, " code"}, int'(rate_code_o), 0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    wait_clk(5);
    check("R1 code during reset", int'(rate_code_o), 0);
    rst_n = 1'b1;
    wait_clk(3);
    check("R1 locked after reset", int'(locked_o), 0);
    check("R1 code after reset", int'(rate_code_o), 0);
    check("R1 irq_n after reset", int'(irq_n_o), 1);
    valid_n_i = 1'b0;
  endtask

  task automatic t_pcm_rates;
    settle(48000.0, 1'b0);  expect_lock("R2 48k", 3);
    settle(32000.0, 1'b0);  expect_lock("R2 32k", 1);
    settle(44100.0, 1'b0);  expect_lock("R2 44.1k", 2);
    settle(384000.0, 1'b0); expect_lock("R2 384k", 9);
    settle(192000.0, 1'b0); expect_lock("R2 192k", 7);
  endtask

  task automatic t_rate_change;
    settle(48000.0, 1'b0);
    expect_lock("R7 before change", 3);
    irq_low_seen = 1'b0;
    settle(96000.0, 1'b0);
    check("R7 irq_n went low on change", int'(irq_low_seen), 1);
    expect_lock("R7 relocked 96k", 5);
  endtask

  task automatic t_tolerance;
    settle(48000.0 * 1.015, 1'b0); expect_lock("R4 48k +1.5%", 3);
    settle(48000.0 * 0.985, 1'b0); expect_lock("R4 48k -1.5%", 3);
    settle(48000.0 * 1.04, 1'b0);  expect_unlock("R4 48k +4%");
    settle(48000.0 * 0.96, 1'b0);  expect_unlock("R4 48k -4%");
  endtask

  task automatic t_nonstandard;
    settle(64000.0, 1'b0);
    expect_unlock("R5 64k");
  endtask

  task automatic t_valid_pin;
    settle(48000.0, 1'b0);
    expect_lock("R8 before hold", 3);
    valid_n_i = 1'b1;
    wait_clk(8);
    expect_unlock("R8 hold asserted");
    check("R10 irq_n low after hold", int'(irq_n_o), 0);
    wait_clk(3 * 2048);
    expect_unlock("R8 still held");
    valid_n_i = 1'b0;
    wait_clk(3072);
    check("R6 one window is not enough", int'(locked_o), 0);
    wait_clk(1700);
    expect_lock("R6 locked after two windows", 3);
  endtask

  task automatic t_dsd;
    settle(2822400.0, 1'b1); expect_lock("R3 2.8224M", 10);
    settle(6144000.0, 1'b1); expect_lock("R3 6.144M", 13);
    settle(3072000.0, 1'b1); expect_lock("R3 3.072M", 11);
    settle(5644800.0, 1'b1); expect_lock("R3 5.6448M", 12);
  endtask

  task automatic t_stop;
    settle(48000.0, 1'b0);
    expect_lock("R9 before stop", 3);
    gen_on = 1'b0;
    wait_clk(5400);
    expect_unlock("R9 clock stopped");
    check("R9 irq_n low after stop", int'(irq_n_o), 0);
    prev_win = 0;
  endtask

  initial begin
    t_reset();
    t_pcm_rates();
    t_rate_change();
    t_tolerance();
    t_nonstandard();
    t_valid_pin();
    t_dsd();
    t_stop();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk_ref);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule